// File: doc/BRIEF.md
# Interrupt priority level arbiter

This block merges two kinds of interrupt source into a single requested priority level. Software requests are held in a masked request register. Each software bit is renumbered to a level from 1 to 15. External interrupt lines occupy a separate, higher bit range and count at their own bit position. The block compares the requested level with a current-level register. When a check strobe arrives and the requested level is strictly above the current one, the block emits a one-cycle take pulse and latches two values: an interrupt summary, which holds one bit per pending source, and an interrupt ID, which holds the winning level.

Both the software-request register and the current-level register are written through simple write-enable ports, and each keeps only its defined bits. The exception sequencer consumes the take pulse and the latched ID. Vectoring to a handler is not done here.

Top module: `ipl_arbiter`

## Requirements
- R1: After reset, take_o is 0, summary_o is 0 and int_id_o is 0. The software-request register and the current-level register both reset to 0.
- R2: A write to the software-request register keeps only bits 4 to 18 of sw_wdata_i (mask 0x7fff0). Bits outside that range never produce a request.
- R3: A pending software bit at position i (4 to 18) requests level i-3, so position 4 gives level 1 and position 18 gives level 15.
- R4: A pending external bit at position i inside the external range (20 to 23 by default) requests level i. External bits outside that range are ignored.
- R5: When several sources are pending, the highest pending position decides the level. Any pending external source wins over every software source.
- R6: On a take, summary_o holds a 1 at the position of every pending in-range software and external bit, and 0 elsewhere.
- R7: An interrupt is taken only when the requested level is non-zero and strictly greater than the current level. An equal level is not taken.
- R8: take_o is high for exactly the one cycle after a clock edge at which check_i was high and R7 held. summary_o and int_id_o are written only on a take and hold their values otherwise.
- R9: A write to the current-level register keeps only bits 4:0 of lvl_wdata_i.
- R10: Without check_i, no take occurs, even while a request above the current level is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_we_i | input | 1 | Write enable of the software-request register |
| sw_wdata_i | input | 32 | Write data for the software-request register |
| lvl_we_i | input | 1 | Write enable of the current-level register |
| lvl_wdata_i | input | 32 | Write data for the current-level register |
| ext_irq_i | input | 32 | External interrupt lines, one per bit position |
| check_i | input | 1 | Strobe that evaluates pending requests |
| take_o | output | 1 | One-cycle interrupt-take pulse |
| summary_o | output | 32 | Latched summary of pending sources |
| int_id_o | output | 5 | Latched level of the taken interrupt |

## Verification
The arbiter is driven with each of the following, then checked:
- a single software bit at the bottom of its range and one at the top, which pins down the renumbering;
- all software bits together, which shows that the highest position wins;
- a software bit combined with an external bit, which shows that external sources win;
- two external bits, which shows ordering inside the external range.

Some requests carry only bits that must be dropped: bits outside the software mask, or external bits outside the external range. These show that masked bits raise nothing and leave the latched summary unchanged. The current level is set to exactly the requested level to separate "strictly greater" from "greater or equal". It is also written with upper bits set, which shows that only five bits are kept. Idle cycles with a pending request show that nothing happens without the strobe.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int unsigned IPL_VEC_W  = 32;
  localparam int unsigned IPL_LVL_W  = 5;
  localparam int unsigned IPL_SW_LO  = 4;
  localparam int unsigned IPL_SW_N   = 15;
  localparam int unsigned IPL_EXT_LO = 20;
  localparam int unsigned IPL_EXT_N  = 4;
endpackage

// File: rtl/ipl_src_regs.sv
module ipl_src_regs #(
  parameter int unsigned VEC_W = ipl_pkg::IPL_VEC_W,
  parameter int unsigned LVL_W = ipl_pkg::IPL_LVL_W,
  parameter int unsigned SW_LO = ipl_pkg::IPL_SW_LO,
  parameter int unsigned SW_N  = ipl_pkg::IPL_SW_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [VEC_W-1:0] sw_wdata_i,
  input  logic             lvl_we_i,
  input  logic [VEC_W-1:0] lvl_wdata_i,
  output logic [VEC_W-1:0] sw_req_o,
  output logic [LVL_W-1:0] cur_lvl_o
);
  localparam int unsigned SW_HI = SW_LO + SW_N - 1;

  logic [VEC_W-1:0] sw_mask;

  for (genvar b = 0; b < VEC_W; b++) begin : g_mask
    assign sw_mask[b] = (b >= SW_LO) && (b <= SW_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_req_o  <= '0;
      cur_lvl_o <= '0;
    end else begin
      if (sw_we_i)  sw_req_o  <= sw_wdata_i & sw_mask;
      if (lvl_we_i) cur_lvl_o <= lvl_wdata_i[LVL_W-1:0];
    end
  end

  // R2: only software range survives a write
  a_r2_sw_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> (sw_req_o == ($past(sw_wdata_i) & sw_mask)));
  // R9: level keeps low bits only
  a_r9_lvl_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_we_i |=> (cur_lvl_o == $past(lvl_wdata_i[LVL_W-1:0])));
endmodule

// File: rtl/ipl_level_enc.sv
module ipl_level_enc #(
  parameter int unsigned VEC_W  = ipl_pkg::IPL_VEC_W,
  parameter int unsigned LVL_W  = ipl_pkg::IPL_LVL_W,
  parameter int unsigned SW_LO  = ipl_pkg::IPL_SW_LO,
  parameter int unsigned SW_N   = ipl_pkg::IPL_SW_N,
  parameter int unsigned EXT_LO = ipl_pkg::IPL_EXT_LO,
  parameter int unsigned EXT_N  = ipl_pkg::IPL_EXT_N
) (
  input  logic [VEC_W-1:0] sw_req_i,
  input  logic [VEC_W-1:0] ext_irq_i,
  output logic [LVL_W-1:0] req_lvl_o,
  output logic [VEC_W-1:0] pend_o
);
  localparam int unsigned SW_HI  = SW_LO + SW_N - 1;
  localparam int unsigned EXT_HI = EXT_LO + EXT_N - 1;

  // software first, external after: later (higher) hits override
  always_comb begin
    req_lvl_o = '0;
    pend_o    = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req_i[i]) begin
        req_lvl_o = LVL_W'(i - SW_LO + 1);
        pend_o[i] = 1'b1;
      end
    end
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (ext_irq_i[i]) begin
        req_lvl_o = LVL_W'(i);
        pend_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter #(
  parameter int unsigned VEC_W  = ipl_pkg::IPL_VEC_W,
  parameter int unsigned LVL_W  = ipl_pkg::IPL_LVL_W,
  parameter int unsigned SW_LO  = ipl_pkg::IPL_SW_LO,
  parameter int unsigned SW_N   = ipl_pkg::IPL_SW_N,
  parameter int unsigned EXT_LO = ipl_pkg::IPL_EXT_LO,
  parameter int unsigned EXT_N  = ipl_pkg::IPL_EXT_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [VEC_W-1:0] sw_wdata_i,
  input  logic             lvl_we_i,
  input  logic [VEC_W-1:0] lvl_wdata_i,
  input  logic [VEC_W-1:0] ext_irq_i,
  input  logic             check_i,
  output logic             take_o,
  output logic [VEC_W-1:0] summary_o,
  output logic [LVL_W-1:0] int_id_o
);
  localparam int unsigned EXT_HI = EXT_LO + EXT_N - 1;

  logic [VEC_W-1:0] sw_req, pend;
  logic [LVL_W-1:0] cur_lvl, req_lvl;
  logic [VEC_W-1:0] ext_mask;
  logic             take_d;

  for (genvar b = 0; b < VEC_W; b++) begin : g_ext_mask
    assign ext_mask[b] = (b >= EXT_LO) && (b <= EXT_HI);
  end

  ipl_src_regs #(
    .VEC_W(VEC_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_N(SW_N)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .lvl_we_i   (lvl_we_i),
    .lvl_wdata_i(lvl_wdata_i),
    .sw_req_o   (sw_req),
    .cur_lvl_o  (cur_lvl)
  );

  ipl_level_enc #(
    .VEC_W(VEC_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_N(SW_N),
    .EXT_LO(EXT_LO), .EXT_N(EXT_N)
  ) i_enc (
    .sw_req_i (sw_req),
    .ext_irq_i(ext_irq_i),
    .req_lvl_o(req_lvl),
    .pend_o   (pend)
  );

  assign take_d = check_i && (req_lvl != '0) && (req_lvl > cur_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o    <= 1'b0;
      summary_o <= '0;
      int_id_o  <= '0;
    end else begin
      take_o <= take_d;
      if (take_d) begin
        summary_o <= pend;
        int_id_o  <= req_lvl;
      end
    end
  end

  // R10: a take only follows a strobe
  a_r10_take_needs_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(check_i));
  // R7: taken level strictly above the level in force at the strobe
  a_r7_above_current: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (int_id_o > $past(cur_lvl)));
  // R8: latched outputs move only on a take
  a_r8_hold_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> ($stable(summary_o) && $stable(int_id_o)));
  // R5: any in-range external source forces an external level
  a_r5_ext_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(|(ext_irq_i & ext_mask))) |-> (int_id_o >= LVL_W'(EXT_LO)));
endmodule

// File: tb/test_ipl_arbiter.sv
module test_ipl_arbiter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_we_i = 1'b0;
  logic [31:0] sw_wdata_i = '0;
  logic        lvl_we_i = 1'b0;
  logic [31:0] lvl_wdata_i = '0;
  logic [31:0] ext_irq_i = '0;
  logic        check_i = 1'b0;
  logic        take_o;
  logic [31:0] summary_o;
  logic [4:0]  int_id_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_sw = '0;
  logic [4:0]  m_lvl = '0;
  logic [31:0] m_sum = '0;
  logic [4:0]  m_id = '0;

  logic [37:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  ipl_arbiter i_ipl_arbiter (
    .clk_i, .rst_ni, .sw_we_i, .sw_wdata_i, .lvl_we_i, .lvl_wdata_i,
    .ext_irq_i, .check_i, .take_o, .summary_o, .int_id_o
  );

  task automatic cmp(string req, logic [37:0] act, logic [37:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual take=%0b sum=%h id=%0d expected take=%0b sum=%h id=%0d",
               req, act[37], act[36:5], act[4:0], exp[37], exp[36:5], exp[4:0]);
    end
  endtask

  task automatic write_sw(logic [31:0] v);
    @(negedge clk_i); sw_we_i = 1'b1; sw_wdata_i = v;
    @(negedge clk_i); sw_we_i = 1'b0;
    m_sw = v & 32'h0007_fff0;  // R2
  endtask

  task automatic write_lvl(logic [31:0] v);
    @(negedge clk_i); lvl_we_i = 1'b1; lvl_wdata_i = v;
    @(negedge clk_i); lvl_we_i = 1'b0;
    m_lvl = v[4:0];  // R9
  endtask

  // driver: one strobe, expected result pushed to the scoreboard
  task automatic check_with(logic [31:0] ext, string req);
    logic [4:0]  l = '0;
    logic [31:0] s = '0;
    logic        tk;
    for (int i = 4; i <= 18; i++) if (m_sw[i]) begin l = 5'(i - 3); s[i] = 1'b1; end
    for (int i = 20; i <= 23; i++) if (ext[i]) begin l = 5'(i); s[i] = 1'b1; end
    tk = (l != 0) && (l > m_lvl);
    if (tk) begin m_sum = s; m_id = l; end
    @(negedge clk_i); ext_irq_i = ext; check_i = 1'b1;
    exp_q.push_back({tk, m_sum, m_id});
    tag_q.push_back(req);
    @(negedge clk_i); check_i = 1'b0;
    // R8: pulse lasts one cycle
    @(negedge clk_i);
    cmp("R8 pulse", {take_o, summary_o, int_id_o}, {1'b0, m_sum, m_id});
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      if (check_i) begin
        @(negedge clk_i);
        if (exp_q.size() != 0) begin
          logic [37:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          cmp(t, {take_o, summary_o, int_id_o}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cmp("R1 reset", {take_o, summary_o, int_id_o}, 38'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R1 after release", {take_o, summary_o, int_id_o}, 38'd0);
    check_with(32'h0, "R1 R7 nothing pending");

    write_sw(32'hffff_ffff);
    check_with(32'h0, "R2 R3 R5 R6 all software bits");
    write_sw(32'h0000_0010);
    check_with(32'h0, "R3 lowest software bit level 1");
    write_sw(32'h0008_000f);
    check_with(32'h0, "R2 R8 masked software bits hold");

    write_sw(32'h0004_0000);
    check_with(32'h0010_0000, "R5 R6 external over software");
    write_sw(32'h0);
    check_with(32'h00a0_0000, "R4 R5 highest external");
    check_with(32'h0108_0001, "R4 out-of-range external ignored");

    write_lvl(32'h0000_002a);
    write_sw(32'h0000_2000);
    check_with(32'h0, "R7 R9 equal level not taken");
    write_sw(32'h0000_4000);
    check_with(32'h0, "R9 R3 level 11 above 10");

    write_lvl(32'h0000_001f);
    check_with(32'h0080_0000, "R7 level 31 blocks external");

    write_lvl(32'h0);
    write_sw(32'h0000_0100);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      cmp("R10 no strobe", {take_o, summary_o, int_id_o}, {1'b0, m_sum, m_id});
    end
    check_with(32'h0, "R3 R10 strobe finally taken");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule